// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges several reasons for resetting a chip into one synchronous, active-high system reset and records the cause that was active last. The causes are:

- the power-on reset input;
- an active-low external reset pin;
- a comparator result that says the non-inverting input is below the inverting input;
- a timeout strobe from a missing-clock detector that runs on its own reference clock;
- an overflow strobe from a watchdog.

Every cause holds the reset for a fixed tail of cycles after it goes away. This gives downstream logic a clean and predictable release.

The external pin is asynchronous, so it passes through a two-flop synchronizer before it can start the reset. The comparator source and the missing-clock source can each be switched on by software. The comparator enable is the same bit that later reports a comparator reset. The cause flags change only at the moment the reset is released. At that moment, the flag of the last cause becomes the only bit set.

Top module: `reset_hub`

## Requirements
- R1: When `ext_rst_n` has been low for two consecutive clock edges, `sys_rst` is high after the following edge.
- R2: `sys_rst` stays high for exactly 12 clock cycles after the last cycle in which any cause was sampled. A single-cycle watchdog strobe therefore gives 13 cycles of reset.
- R3: After a release from an external-pin reset, `src_flags` reads 0x01 (bit 0).
- R4: With the missing-clock enable set (bit 7 written at `reg_addr`=1), a `mcd_timeout` strobe causes a reset, and the release leaves `src_flags` at 0x04 (bit 2). With the enable clear, the strobe changes neither `sys_rst` nor `src_flags`.
- R5: Writing bit 5 at `reg_addr`=0 enables the comparator. While it is enabled, `cmp_below`=1 asserts `sys_rst`. After a comparator reset, `src_flags` reads 0x20, so bit 5 stays set and the comparator stays enabled.
- R6: With bit 5 clear, `cmp_below` changes neither `sys_rst` nor `src_flags`.
- R7: A `wdt_ovf` strobe causes a reset, and the release leaves `src_flags` at 0x08 (bit 3).
- R8: While `rst` is high, `sys_rst` is 1 and `src_flags` is 0x00. After a power-on reset is released, `src_flags` reads 0x02 (bit 1).
- R9: At each release, only the flag of the last active cause is set. All other bits are cleared, including the comparator enable bit 5.
- R10: Register writes made while `sys_rst` is high have no effect. Outside reset, a write at `reg_addr`=0 changes only bit 5.
- R11: When several causes are sampled in the same cycle, the flag is chosen in this priority order: external pin, then missing clock, then comparator, then watchdog.
- R12: Any reset clears the missing-clock enable, so a later timeout strobe is ignored until the enable is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| cmp_below | input | 1 | Comparator result: non-inverting input below inverting input |
| mcd_timeout | input | 1 | Missing-clock timeout strobe |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the cause-flag register, 1 selects the clock-monitor control register |
| reg_wdata | input | 8 | Write data |
| sys_rst | output | 1 | Synchronous system reset, active high |
| src_flags | output | 8 | Cause-flag register |

## Verification
Several properties are checked on every cycle:

- a synchronized low pin always leads to reset;
- any sampled cause asserts reset on the next edge;
- a running tail counter keeps the reset asserted;
- the flags stay frozen through a reset and are one-hot at each release.

Other behaviours only show up in the bench's scenarios. These are the exact 13-cycle length after a single strobe, the choice among simultaneous causes, the enables being ignored or cleared, and writes being dropped during reset. The bench's reference model is compared against these on every clock.

// File: rtl/rh_pkg.sv
package rh_pkg;
    localparam int FLAG_W       = 8;
    localparam int BIT_PIN      = 0;
    localparam int BIT_POR      = 1;
    localparam int BIT_MCD      = 2;
    localparam int BIT_WDT      = 3;
    localparam int BIT_CMP      = 5;
    localparam int CTRL_MCD_BIT = 7;

    typedef enum logic [2:0] {
        SRC_POR = 3'd0,
        SRC_PIN = 3'd1,
        SRC_MCD = 3'd2,
        SRC_CMP = 3'd3,
        SRC_WDT = 3'd4
    } src_e;

    typedef enum logic {
        REG_SRC = 1'b0,
        REG_CLK = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic por;
        logic pin;
        logic mcd;
        logic cmp;
        logic wdt;
    } cause_t;

    function automatic logic any_cause(cause_t c);
        return c.por | c.pin | c.mcd | c.cmp | c.wdt;
    endfunction

    // Priority among causes sampled in the same cycle
    function automatic src_e pick_src(cause_t c, src_e prev);
        if (c.por)      return SRC_POR;
        else if (c.pin) return SRC_PIN;
        else if (c.mcd) return SRC_MCD;
        else if (c.cmp) return SRC_CMP;
        else if (c.wdt) return SRC_WDT;
        else            return prev;
    endfunction

    function automatic logic [FLAG_W-1:0] src_flag(src_e s);
        logic [FLAG_W-1:0] f;
        f = '0;
        case (s)
            SRC_POR: f[BIT_POR] = 1'b1;
            SRC_PIN: f[BIT_PIN] = 1'b1;
            SRC_MCD: f[BIT_MCD] = 1'b1;
            SRC_CMP: f[BIT_CMP] = 1'b1;
            SRC_WDT: f[BIT_WDT] = 1'b1;
            default: f = '0;
        endcase
        return f;
    endfunction
endpackage

// File: rtl/rh_pin_sync.sv
module rh_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pin_n_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b1;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign pin_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rh_stretch.sv
module rh_stretch #(
    parameter int HOLD = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic any_i,
    output logic rst_o,
    output logic exit_o
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

    logic [CW-1:0] cnt_q;
    logic          rst_q;

    always_ff @(posedge clk) begin
        if (rst || any_i) begin
            cnt_q <= HOLD_V;
            rst_q <= 1'b1;
        end else begin
            rst_q <= (cnt_q != '0);
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign rst_o  = rst_q;
    assign exit_o = rst_q && !any_i && (cnt_q == '0);

    // R2
    cause_sets_rst_chk: assert property (@(posedge clk) disable iff (rst)
        any_i |=> rst_o);

    // R2
    tail_holds_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_o && cnt_q != '0) |=> rst_o);
endmodule

// File: rtl/rh_recorder.sv
module rh_recorder
    import rh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cause_t            cause_i,
    input  logic              any_i,
    input  logic              in_rst_i,
    input  logic              exit_i,
    input  logic              wr_i,
    input  logic              sel_i,
    input  logic [FLAG_W-1:0] wdata_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              cmp_en_o,
    output logic              mcd_en_o
);
    logic [FLAG_W-1:0] flags_q;
    src_e              last_q;
    logic              mcd_en_q;
    logic              wr_ok;

    assign wr_ok = wr_i && !in_rst_i && !any_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '0;
            last_q   <= SRC_POR;
            mcd_en_q <= 1'b0;
        end else begin
            if (any_i) begin
                last_q   <= pick_src(cause_i, last_q);
                mcd_en_q <= 1'b0;
            end
            if (exit_i) begin
                flags_q <= src_flag(last_q);
            end else if (wr_ok) begin
                if (reg_sel_e'(sel_i) == REG_SRC) flags_q[BIT_CMP] <= wdata_i[BIT_CMP];
                else                              mcd_en_q <= wdata_i[CTRL_MCD_BIT];
            end
        end
    end

    assign flags_o  = flags_q;
    assign cmp_en_o = flags_q[BIT_CMP];
    assign mcd_en_o = mcd_en_q;

    // R10
    flags_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (in_rst_i && $past(in_rst_i)) |-> $stable(flags_o));

    // R9
    exit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(in_rst_i) |-> $onehot(flags_o));
endmodule

// File: rtl/reset_hub.sv
module reset_hub
    import rh_pkg::*;
#(
    parameter int HOLD_CYCLES = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst_n,
    input  logic              cmp_below,
    input  logic              mcd_timeout,
    input  logic              wdt_ovf,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [FLAG_W-1:0] reg_wdata,
    output logic              sys_rst,
    output logic [FLAG_W-1:0] src_flags
);
    logic   pin_n_s;
    logic   cmp_en;
    logic   mcd_en;
    logic   any;
    logic   exit_now;
    cause_t cause;

    rh_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin_n      (ext_rst_n),
        .pin_n_sync (pin_n_s)
    );

    always_comb begin
        cause.por = rst;
        cause.pin = !pin_n_s;
        cause.mcd = mcd_en && mcd_timeout;
        cause.cmp = cmp_en && cmp_below;
        cause.wdt = wdt_ovf;
        any       = any_cause(cause);
    end

    rh_stretch #(.HOLD(HOLD_CYCLES)) u_stretch (
        .clk    (clk),
        .rst    (rst),
        .any_i  (any),
        .rst_o  (sys_rst),
        .exit_o (exit_now)
    );

    rh_recorder u_rec (
        .clk      (clk),
        .rst      (rst),
        .cause_i  (cause),
        .any_i    (any),
        .in_rst_i (sys_rst),
        .exit_i   (exit_now),
        .wr_i     (reg_wr),
        .sel_i    (reg_addr),
        .wdata_i  (reg_wdata),
        .flags_o  (src_flags),
        .cmp_en_o (cmp_en),
        .mcd_en_o (mcd_en)
    );

    // R1
    pin_low_resets_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_n_s |=> sys_rst);
endmodule

// File: tb/reset_hub_test.sv
module reset_hub_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_rst_n = 1'b1;
    logic       cmp_below = 1'b0;
    logic       mcd_timeout = 1'b0;
    logic       wdt_ovf = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       sys_rst;
    logic [7:0] src_flags;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    bit       m_s1 = 1'b1, m_s2 = 1'b1, m_rq = 1'b1, m_mcd_en = 1'b0;
    int       m_cnt = 12;
    int       m_last = 0;
    bit [7:0] m_flags = 8'h00;
    bit       cmp_on = 1'b0;

    always #2 clk = ~clk;

    reset_hub uut (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .cmp_below(cmp_below),
        .mcd_timeout(mcd_timeout), .wdt_ovf(wdt_ovf), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .sys_rst(sys_rst), .src_flags(src_flags)
    );

    function automatic bit [7:0] flag_of(int s);
        case (s)
            0: return 8'h02;
            1: return 8'h01;
            2: return 8'h04;
            3: return 8'h20;
            default: return 8'h08;
        endcase
    endfunction

    always @(posedge clk) begin
        bit c_pin, c_mcd, c_cmp, c_any, leave, okw;
        c_pin = !m_s2;
        c_mcd = m_mcd_en && mcd_timeout;
        c_cmp = m_flags[5] && cmp_below;
        c_any = rst || c_pin || c_mcd || c_cmp || wdt_ovf;
        leave = m_rq && !c_any && m_cnt == 0;
        okw   = reg_wr && !m_rq && !c_any;
        m_s2 = rst ? 1'b1 : m_s1;
        m_s1 = rst ? 1'b1 : ext_rst_n;
        if (rst) begin
            m_flags = 8'h00; m_last = 0; m_mcd_en = 0;
        end else begin
            if (c_any) begin
                m_last = c_pin ? 1 : c_mcd ? 2 : c_cmp ? 3 : 4;
                m_mcd_en = 0;
            end
            if (leave) m_flags = flag_of(m_last);
            else if (okw) begin
                if (!reg_addr) m_flags[5] = reg_wdata[5];
                else m_mcd_en = reg_wdata[7];
            end
        end
        if (c_any) begin
            m_cnt = 12; m_rq = 1;
        end else begin
            m_rq = (m_cnt != 0);
            if (m_cnt != 0) m_cnt--;
        end
        cmp_on = 1'b1;
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (sys_rst !== m_rq) begin
                errors++;
                $display("FAIL R2 model sys_rst actual %0b expected %0b", sys_rst, m_rq);
            end
            checks++;
            if (src_flags !== m_flags) begin
                errors++;
                $display("FAIL R9 model src_flags actual %02h expected %02h", src_flags, m_flags);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_exit();
        for (int i = 0; i < 200 && sys_rst; i++) @(negedge clk);
    endtask

    task automatic write_reg(input bit a, input bit [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic pulse(input bit w, input bit m, input bit c);
        @(negedge clk);
        wdt_ovf = w; mcd_timeout = m; cmp_below = c;
        @(negedge clk);
        wdt_ovf = 0; mcd_timeout = 0; cmp_below = 0;
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        check("R8 reset sys_rst", sys_rst, 1);
        check("R8 reset flags", src_flags, 8'h00);
        rst = 0;
        wait_exit();
        check("R8 por flags", src_flags, 8'h02);

        pulse(1, 0, 0);
        n = 0;
        while (sys_rst && n < 100) begin n++; @(negedge clk); end
        check("R2 stretch length", n, 13);
        check("R7 wdt flags", src_flags, 8'h08);

        @(negedge clk); cmp_below = 1;
        repeat (5) @(negedge clk);
        check("R6 cmp disabled sys_rst", sys_rst, 0);
        cmp_below = 0;
        check("R6 cmp disabled flags", src_flags, 8'h08);

        write_reg(0, 8'hFF);
        check("R10 only bit5 writable", src_flags, 8'h28);
        write_reg(0, 8'h00);
        check("R10 clear bit5", src_flags, 8'h08);
        write_reg(0, 8'h20);

        @(negedge clk); cmp_below = 1;
        repeat (3) @(negedge clk);
        check("R5 cmp reset", sys_rst, 1);
        cmp_below = 0;
        wait_exit();
        check("R5 cmp flags", src_flags, 8'h20);

        pulse(0, 1, 0);
        repeat (3) @(negedge clk);
        check("R4 mcd disabled sys_rst", sys_rst, 0);
        check("R4 mcd disabled flags", src_flags, 8'h20);

        pulse(1, 0, 0);
        wait_exit();
        check("R9 bit5 cleared by wdt", src_flags, 8'h08);

        write_reg(1, 8'h80);
        pulse(0, 1, 0);
        check("R4 mcd reset", sys_rst, 1);
        wait_exit();
        check("R4 mcd flags", src_flags, 8'h04);

        pulse(0, 1, 0);
        repeat (3) @(negedge clk);
        check("R12 enable cleared", sys_rst, 0);
        check("R12 flags kept", src_flags, 8'h04);

        pulse(1, 0, 0);
        write_reg(0, 8'h20);
        write_reg(1, 8'h80);
        wait_exit();
        check("R10 write in reset dropped", src_flags, 8'h08);
        pulse(0, 1, 0);
        repeat (3) @(negedge clk);
        check("R10 mcd write in reset dropped", sys_rst, 0);

        @(negedge clk); ext_rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1 pin reset", sys_rst, 1);
        pulse(1, 0, 0);
        repeat (3) @(negedge clk);
        ext_rst_n = 1;
        wait_exit();
        check("R3 pin flags", src_flags, 8'h01);

        write_reg(0, 8'h20);
        write_reg(1, 8'h80);
        pulse(1, 1, 1);
        wait_exit();
        check("R11 mcd beats cmp and wdt", src_flags, 8'h04);
        write_reg(0, 8'h20);
        pulse(1, 0, 1);
        wait_exit();
        check("R11 cmp beats wdt", src_flags, 8'h20);

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule